// File: doc/BRIEF.md
# Latched Channel-Select Controller

This block is the digital control for an analog multiplexer. It holds a binary channel number and an enable bit in a pair of write-gated holding registers. It decodes them into at most one active switch-enable line. An active-low write strobe sets whether the holding registers track the inputs or keep their contents. An active-low master reset clears them and turns every switch off. All strobes are sampled on one clock.

Between the decoder and the switch-enable outputs sits a sequencer. When the selection moves from one live channel to a different live channel, it first drives every output low for a fixed number of cycles and only then turns the new one on. This break-before-make behaviour stops two analog inputs from being briefly shorted together. Moves to or from the all-off state need no gap and are applied at once.

A parameter selects one of two variants. The single-ended variant has eight channels addressed by three bits. The differential variant has four channels addressed by two bits, and each enable line drives both switches of one pair.

Top module: `chan_sel_ctrl`

## Requirements
- R1: With DIFF_MODE=0, a held enable of 1 and held channel number N (0..7, addr bit 0 as LSB) drive sw_en[N] high and every other bit low.
- R2: With DIFF_MODE=1, only addr[1:0] selects the channel (0..3) and addr[2] has no effect. sw_en[7:4] is always 0.
- R3: On every rising clock edge where wr_n is 0, the holding registers load addr and en. The resulting change reaches sw_en at the following edge, two edges after the inputs were applied.
- R4: On a rising edge where wr_n is 1, the holding registers keep their contents, so changes on addr and en have no effect on sw_en.
- R5: On a rising edge where rst_n is 0, the holding registers clear and sw_en becomes all zero, whatever wr_n, en and addr are.
- R6: After rst_n returns to 1, sw_en stays all zero until a write loads a selection with enable 1.
- R7: A held enable of 0 forces sw_en to all zero, whatever the held channel number.
- R8: When the output moves from one live channel to a different live channel, sw_en is all zero for exactly BBM_CYCLES cycles before the new bit rises.
- R9: A move from all-off to a channel, or from a channel to all-off, is applied at the next edge with no gap.
- R10: A write that reloads the channel and enable already being driven causes no gap and no change on sw_en.
- R11: A reset during the break-before-make gap abandons the pending channel. sw_en stays zero after the reset and does not switch on when the gap would have ended.
- R12: On every cycle, sw_en is either all zero or has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Active-low master reset, synchronous, overrides everything |
| wr_n | input | 1 | Active-low write strobe; low = holding registers track inputs |
| en | input | 1 | Enable bit loaded with the channel number |
| addr | input | 3 | Binary channel number (bit 2 unused in differential mode) |
| sw_en | output | 8 | Switch-enable lines, all zero or one-hot |

## Verification
The bench builds two instances side by side from the same stimulus. One is single-ended with a gap of 2 cycles and the other is differential with a gap of 3 cycles. Two gap lengths expose any off-by-one in the gap counter. The differential instance sees addresses that differ only in bit 2, so a single write is a channel change for one instance and a same-channel reload for the other. This shows R2 and R10 against R8 in one trace.

// File: rtl/chan_sel_pkg.sv
package chan_sel_pkg;

  typedef enum logic {
    SEQ_STEADY = 1'b0,
    SEQ_GAP    = 1'b1
  } seq_state_e;

  // A move needs the off-gap only between two distinct live channels.
  function automatic logic needs_gap(input logic [7:0] cur, input logic [7:0] nxt);
    return (cur != '0) && (nxt != '0) && (cur != nxt);
  endfunction

endpackage

// File: rtl/sel_latch.sv
module sel_latch #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] hold_addr,
  output logic              hold_en
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_en   <= 1'b0;
    end else if (!wr_n) begin
      hold_addr <= addr_i;
      hold_en   <= en_i;
    end
  end

  // R4: with the strobe high the held selection does not move
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> ($stable(hold_addr) && $stable(hold_en)));

  // R5: reset empties the holding registers
  assert_latch_cleared_R5: assert property (@(posedge clk)
    !rst_n |=> (hold_en == 1'b0 && hold_addr == '0));

endmodule

// File: rtl/chan_decode.sv
module chan_decode #(
  parameter int ADDR_W = 3,
  parameter int NUM_CH = 8,
  parameter int OUT_W  = 8
) (
  input  logic              hold_en,
  input  logic [ADDR_W-1:0] hold_addr,
  output logic [OUT_W-1:0]  target
);

  for (genvar g = 0; g < OUT_W; g++) begin : g_line
    if (g < NUM_CH) begin : g_live
      assign target[g] = hold_en && (hold_addr == ADDR_W'(g));
    end else begin : g_tied
      assign target[g] = 1'b0;
    end
  end

  // R12: the decoder never asks for two lines at once
  always_comb begin
    assert_decode_onehot_R12: assert ($onehot0(target) || $isunknown(target));
  end

endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
  import chan_sel_pkg::*;
#(
  parameter int OUT_W      = 8,
  parameter int BBM_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OUT_W-1:0] target,
  output logic [OUT_W-1:0] sw_q
);

  localparam int CNT_W = (BBM_CYCLES < 2) ? 1 : $clog2(BBM_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BBM_CYCLES - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] gap_cnt;
  logic             swap_req;
  logic             gap_done;

  assign swap_req = needs_gap(8'(sw_q), 8'(target));
  assign gap_done = (gap_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_STEADY;
      gap_cnt <= '0;
      sw_q    <= '0;
    end else begin
      case (state)
        SEQ_STEADY: begin
          if (swap_req) begin
            sw_q    <= '0;
            gap_cnt <= '0;
            state   <= SEQ_GAP;
          end else begin
            sw_q <= target;
          end
        end
        SEQ_GAP: begin
          if (gap_done) begin
            sw_q  <= target;
            state <= SEQ_STEADY;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= SEQ_STEADY;
      endcase
    end
  end

  // R8: one live line never hands over straight to another
  assert_break_before_make_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q != '0) |=> (sw_q == '0 || sw_q == $past(sw_q)));

  // R12: outputs are all zero or one-hot
  assert_out_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_q));

  // R11: reset abandons the gap
  assert_reset_aborts_gap_R11: assert property (@(posedge clk)
    !rst_n |=> (sw_q == '0 && state == SEQ_STEADY));

endmodule

// File: rtl/chan_sel_ctrl.sv
module chan_sel_ctrl #(
  parameter bit DIFF_MODE  = 1'b0,
  parameter int BBM_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_n,
  input  logic       en,
  input  logic [2:0] addr,
  output logic [7:0] sw_en
);

  localparam int OUT_W  = 8;
  localparam int NUM_CH = DIFF_MODE ? 4 : 8;
  localparam int ADDR_W = $clog2(NUM_CH);

  logic [ADDR_W-1:0] hold_addr;
  logic              hold_en;
  logic [OUT_W-1:0]  target;

  sel_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_n      (wr_n),
    .en_i      (en),
    .addr_i    (addr[ADDR_W-1:0]),
    .hold_addr (hold_addr),
    .hold_en   (hold_en)
  );

  chan_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .OUT_W(OUT_W)) u_decode (
    .hold_en   (hold_en),
    .hold_addr (hold_addr),
    .target    (target)
  );

  bbm_seq #(.OUT_W(OUT_W), .BBM_CYCLES(BBM_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .target (target),
    .sw_q   (sw_en)
  );

  // R7: a held enable of 0 turns everything off at the next edge
  assert_disabled_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> (sw_en == '0));

  // R5: reset forces the outputs off whatever the other inputs do
  assert_reset_clears_R5: assert property (@(posedge clk)
    !rst_n |=> (sw_en == '0));

  if (NUM_CH < OUT_W) begin : g_upper_idle
    // R2: unused upper lines stay low in the four-channel variant
    assert_upper_lines_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_en[OUT_W-1:NUM_CH] == '0);
  end

endmodule

// File: tb/chan_sel_ctrl_tb.sv
module chan_sel_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic       en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] sw_se;
  logic [7:0] sw_df;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  chan_sel_ctrl #(.DIFF_MODE(1'b0), .BBM_CYCLES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en), .addr(addr), .sw_en(sw_se));

  chan_sel_ctrl #(.DIFF_MODE(1'b1), .BBM_CYCLES(3)) u_dut_diff (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en), .addr(addr), .sw_en(sw_df));

  // Reference state per instance: 0 = single-ended, 1 = differential
  int         m_nch [2] = '{8, 4};
  int         m_bbm [2] = '{2, 3};
  logic [2:0] m_addr[2];
  logic       m_en  [2];
  logic [7:0] m_out [2];
  int         m_left[2];

  logic [7:0] exp_se_q[$];
  logic [7:0] exp_df_q[$];
  string      tag_q[$];

  // Advance the reference by one rising edge with the given inputs
  task automatic model_edge(input int i, input logic r, input logic w,
                            input logic e, input logic [2:0] a);
    logic [7:0] want;
    want = m_en[i] ? (8'd1 << (int'(m_addr[i]) % m_nch[i])) : 8'd0;
    if (!r) begin
      m_addr[i] = '0; m_en[i] = 1'b0; m_out[i] = '0; m_left[i] = 0;
    end else begin
      if (m_left[i] > 0) begin
        m_left[i] = m_left[i] - 1;
        if (m_left[i] == 0) m_out[i] = want;
      end else if (m_out[i] != 0 && want != 0 && want != m_out[i]) begin
        m_out[i]  = '0;
        m_left[i] = m_bbm[i];
      end else begin
        m_out[i] = want;
      end
      if (!w) begin m_addr[i] = a; m_en[i] = e; end
    end
  endtask

  task automatic step(input logic r, input logic w, input logic e,
                      input logic [2:0] a, input string tag);
    @(negedge clk);
    rst_n = r; wr_n = w; en = e; addr = a;
    for (int i = 0; i < 2; i++) model_edge(i, r, w, e, a);
    exp_se_q.push_back(m_out[0]);
    exp_df_q.push_back(m_out[1]);
    tag_q.push_back(tag);
  endtask

  task automatic write(input logic e, input logic [2:0] a, input string tag);
    step(1'b1, 1'b0, e, a, tag);
    step(1'b1, 1'b1, e, a, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b1, 1'b1, en, addr, tag);
  endtask

  // Monitor: pop and compare shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (tag_q.size() > 0) begin
        logic [7:0] es;
        logic [7:0] ed;
        string t;
        es = exp_se_q.pop_front();
        ed = exp_df_q.pop_front();
        t  = tag_q.pop_front();
        checks += 2;
        if (sw_se !== es) begin
          errors++;
          $display("FAIL %s single-ended: sw_en=%b expected %b", t, sw_se, es);
        end
        if (sw_df !== ed) begin
          errors++;
          $display("FAIL %s differential: sw_en=%b expected %b", t, sw_df, ed);
        end
        checks += 1;
        if (!$onehot0(sw_se) || !$onehot0(sw_df)) begin
          errors++;
          $display("FAIL R12 onehot: se=%b df=%b expected zero or one bit", sw_se, sw_df);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_addr[i] = '0; m_en[i] = 1'b0; m_out[i] = '0; m_left[i] = 0;
    end
    // R5: reset state, even with a write pending on the inputs
    step(1'b0, 1'b0, 1'b1, 3'd4, "R5");
    step(1'b0, 1'b0, 1'b1, 3'd4, "R5");
    // R6: released, strobe high, inputs set but not written
    step(1'b1, 1'b1, 1'b1, 3'd5, "R6");
    idle(3, "R6");
    // R1 / R3 / R9: first write from all-off, no gap
    write(1'b1, 3'd3, "R1");
    idle(2, "R1");
    // R4: inputs move while strobe high
    step(1'b1, 1'b1, 1'b1, 3'd6, "R4");
    step(1'b1, 1'b1, 1'b0, 3'd1, "R4");
    idle(2, "R4");
    // R8: live-to-live change, gap of 2 and 3 cycles
    write(1'b1, 3'd6, "R8");
    idle(5, "R8");
    // R10: reload of the active selection
    write(1'b1, 3'd6, "R10");
    idle(3, "R10");
    // R2 / R10: bit 2 only differs: change for one, reload for the other
    write(1'b1, 3'd2, "R2");
    idle(5, "R2");
    // R7 / R9: enable cleared turns off at once
    write(1'b0, 3'd5, "R7");
    idle(2, "R7");
    // R9: from all-off straight on
    write(1'b1, 3'd7, "R9");
    idle(2, "R9");
    // R11: reset in the middle of the gap
    write(1'b1, 3'd0, "R11");
    step(1'b0, 1'b1, 1'b1, 3'd0, "R11");
    step(1'b1, 1'b1, 1'b1, 3'd0, "R11");
    idle(5, "R11");
    // R3: strobe held low, channel walks every edge
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b1, 3'(k), "R3");
    step(1'b1, 1'b1, 1'b1, 3'd7, "R3");
    idle(6, "R3");
    // R5: reset with strobe low and enable high
    step(1'b0, 1'b0, 1'b1, 3'd1, "R5");
    step(1'b1, 1'b1, 1'b1, 3'd1, "R6");
    idle(3, "R6");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule